// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block divides every nominal CAN bit into time quanta and walks through four segments in a fixed order: a one-quantum sync segment, a propagation segment, a first phase buffer and a second phase buffer. It advances by one quantum for each cycle in which the time-quantum enable is high. It emits a one-clock sample strobe together with the sampled bus level at the boundary between the two phase buffers. It also emits a one-clock bit-start strobe for every sync quantum.

A falling edge on the bus (recessive 1 to dominant 0) resynchronizes the bit. A late edge, seen in the propagation segment or the first phase buffer, stretches the first phase buffer. An early edge, seen in the second phase buffer, trims the second phase buffer. In both cases the correction is clamped to the jump width. A hard-sync request turns the current quantum into a sync quantum. If the segment lengths form an illegal combination, an error output rises and the sequencer is held at the start of a bit.

The bit index of a quantum counts from 0 at the sync quantum. Let P, A, B and J be the propagation, phase-1, phase-2 and jump-width lengths, and let L = 1+P+A+B.

Top module: `can_bit_timer`

## Requirements
- R1: `cfg_err` is 1 exactly when the configuration is illegal. It is 0 only when P is 1..8, A is 2..8, B is 2..8, J is 1..4, A >= B >= J and 8 <= L <= 25.
- R2: While `cfg_err` is 1, neither strobe fires. After the configuration becomes legal, the first enabled quantum is a sync quantum.
- R3: With no falling edges and no hard sync, `bit_start` pulses after the enabled quanta whose index is a multiple of L, counting the first enabled quantum after reset as index 0.
- R4: `sample_stb` pulses after the quantum at bit index P+A (the last quantum of phase 1). On that pulse `rx_bit` holds the bus level of that quantum, and `rx_bit` changes at no other time except reset or an illegal configuration.
- R5: A falling edge at bit index e, with 1 <= e <= P+A, lengthens phase 1 by min(e, J) quanta.
- R6: A falling edge at bit index e in phase 2 shortens phase 2 by min(L-1-e, J) quanta.
- R7: A falling edge during the sync quantum changes no timing.
- R8: At most one resynchronization takes place per bit. Later edges in the same bit are ignored.
- R9: Falling edges cause no resynchronization while `rx_bit` (the last sampled level) is 0.
- R10: A hard-sync request on an enabled quantum at any index h makes that quantum a sync quantum. `bit_start` then pulses after it, the next sample is at h+P+A and the next bit starts at h+L.
- R11: After reset `rx_bit` is 1 and both strobes are 0.
- R12: A strobe is high only in the clock after a clock with `tq_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tq_en | input | 1 | Time-quantum enable; one quantum per high cycle |
| prop_len | input | 4 | Propagation segment length in quanta |
| ph1_len | input | 4 | Phase buffer 1 length in quanta |
| ph2_len | input | 4 | Phase buffer 2 length in quanta |
| sjw_len | input | 3 | Synchronization jump width in quanta |
| rx_in | input | 1 | Bus level, 1 recessive, 0 dominant |
| hsync_req | input | 1 | Hard synchronization request |
| rx_bit | output | 1 | Level taken at the last sample point |
| sample_stb | output | 1 | One-clock sample point strobe |
| bit_start | output | 1 | One-clock strobe after each sync quantum |
| cfg_err | output | 1 | Illegal segment configuration |

## Verification
A constantly recessive bus is run across every legal segment configuration to pin down the bit period and the sample point. A single falling edge is then placed at every quantum index of a bit, for several configurations. This separates edges in the sync quantum, late edges and early edges, and shows where the jump-width clamp takes over from the raw phase error. Two-edge patterns tell a bit that allows one resynchronization from one that allows two. An edge following a dominant sample tells apart a sequencer that gates edges from one that does not. Hard sync is tried before and after the sample point, and a sweep over all input codes compares the legality flag with the range rules.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

    localparam int PROP_MAX = 8;
    localparam int PH_MIN   = 2;
    localparam int PH_MAX   = 8;
    localparam int SJW_MAX  = 4;
    localparam int BIT_MIN  = 8;
    localparam int BIT_MAX  = 25;

    localparam int SEG_W = $clog2(PH_MAX + 1);
    localparam int SJW_W = $clog2(SJW_MAX + 1);
    localparam int CNT_W = $clog2(BIT_MAX + SJW_MAX + 1);

    typedef logic [SEG_W-1:0] seg_len_t;
    typedef logic [SJW_W-1:0] sjw_t;
    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t ONE = cnt_t'(1);

    typedef enum logic [1:0] {
        SEG_SYNC,
        SEG_PROP,
        SEG_PH1,
        SEG_PH2
    } seg_e;

    typedef struct packed {
        seg_len_t prop;
        seg_len_t ph1;
        seg_len_t ph2;
        sjw_t     sjw;
    } bt_cfg_t;

    typedef struct packed {
        seg_e seg;
        cnt_t rem;      // quanta left in segment, current included
        cnt_t qpos;     // bit index of current quantum
        cnt_t ext;      // phase-1 stretch decided during propagation
        logic synced;   // resync already spent in this bit
    } seq_state_t;

    localparam seq_state_t IDLE_ST = '{seg: SEG_SYNC, rem: ONE, qpos: '0,
                                       ext: '0, synced: 1'b0};

    function automatic cnt_t clamp_sjw(cnt_t err, sjw_t sjw);
        cnt_t lim;
        lim = cnt_t'(sjw);
        return (err < lim) ? err : lim;
    endfunction

    function automatic logic cfg_ok(bt_cfg_t c);
        int p, a, b, s, tot;
        p   = int'(c.prop);
        a   = int'(c.ph1);
        b   = int'(c.ph2);
        s   = int'(c.sjw);
        tot = 1 + p + a + b;
        return (p >= 1) && (p <= PROP_MAX) &&
               (a >= PH_MIN) && (a <= PH_MAX) &&
               (b >= PH_MIN) && (b <= PH_MAX) &&
               (s >= 1) && (s <= SJW_MAX) &&
               (a >= b) && (b >= s) &&
               (tot >= BIT_MIN) && (tot <= BIT_MAX);
    endfunction

endpackage

// File: rtl/cbt_cfg_check.sv
module cbt_cfg_check
    import cbt_pkg::*;
(
    input  bt_cfg_t cfg,
    output logic    cfg_bad
);

    always_comb begin
        cfg_bad = !cfg_ok(cfg);
    end

endmodule

// File: rtl/cbt_edge_det.sv
module cbt_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic tq_en,
    input  logic rx_in,
    output logic fall
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
        end else if (tq_en) begin
            prev_q <= rx_in;
        end
    end

    always_comb begin
        fall = tq_en && prev_q && !rx_in;
    end

endmodule

// File: rtl/cbt_seg_seq.sv
module cbt_seg_seq
    import cbt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tq_en,
    input  bt_cfg_t cfg,
    input  logic    cfg_bad,
    input  logic    rx_in,
    input  logic    fall,
    input  logic    hsync,
    output logic    bit_start,
    output logic    sample_stb,
    output logic    rx_bit
);

    seq_state_t st_q, st_d;
    logic       smp_q, smp_d;
    logic       bst_q, bst_d;
    logic       rxb_q, rxb_d;
    logic       resync_ok;
    cnt_t       rem_m1, late_k, early_k, ext_t, cut;

    always_comb begin
        st_d      = st_q;
        smp_d     = 1'b0;
        bst_d     = 1'b0;
        rxb_d     = rxb_q;
        rem_m1    = st_q.rem - ONE;
        late_k    = clamp_sjw(st_q.qpos, cfg.sjw);
        early_k   = clamp_sjw(rem_m1, cfg.sjw);
        resync_ok = fall && !st_q.synced && rxb_q;
        ext_t     = st_q.ext;
        cut       = '0;
        if (cfg_bad) begin
            st_d  = IDLE_ST;
            rxb_d = 1'b1;
        end else if (tq_en) begin
            st_d.qpos = st_q.qpos + ONE;
            if (hsync) begin
                st_d  = '{seg: SEG_PROP, rem: cnt_t'(cfg.prop), qpos: ONE,
                          ext: '0, synced: 1'b1};
                bst_d = 1'b1;
            end else begin
                unique case (st_q.seg)
                    SEG_SYNC: begin
                        st_d  = '{seg: SEG_PROP, rem: cnt_t'(cfg.prop), qpos: ONE,
                                  ext: '0, synced: 1'b0};
                        bst_d = 1'b1;
                    end
                    SEG_PROP: begin
                        if (resync_ok) begin
                            ext_t       = late_k;
                            st_d.synced = 1'b1;
                        end
                        st_d.ext = ext_t;
                        if (st_q.rem == ONE) begin
                            st_d.seg = SEG_PH1;
                            st_d.rem = cnt_t'(cfg.ph1) + ext_t;
                        end else begin
                            st_d.rem = rem_m1;
                        end
                    end
                    SEG_PH1: begin
                        if (resync_ok) begin
                            st_d.synced = 1'b1;
                            st_d.rem    = rem_m1 + late_k;
                        end else if (st_q.rem == ONE) begin
                            st_d.seg = SEG_PH2;
                            st_d.rem = cnt_t'(cfg.ph2);
                            smp_d    = 1'b1;
                            rxb_d    = rx_in;
                        end else begin
                            st_d.rem = rem_m1;
                        end
                    end
                    SEG_PH2: begin
                        if (resync_ok) begin
                            cut         = early_k;
                            st_d.synced = 1'b1;
                        end
                        if (rem_m1 == cut) begin
                            st_d.seg = SEG_SYNC;
                            st_d.rem = ONE;
                        end else begin
                            st_d.rem = rem_m1 - cut;
                        end
                    end
                    default: st_d = IDLE_ST;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= IDLE_ST;
            smp_q <= 1'b0;
            bst_q <= 1'b0;
            rxb_q <= 1'b1;
        end else begin
            st_q  <= st_d;
            smp_q <= smp_d;
            bst_q <= bst_d;
            rxb_q <= rxb_d;
        end
    end

    assign bit_start  = bst_q;
    assign sample_stb = smp_q;
    assign rx_bit     = rxb_q;

    // R12: strobes only follow an enabled quantum
    p_strobe_tq_r12: assert property (@(posedge clk) disable iff (rst)
        (bit_start || sample_stb) |-> $past(tq_en));

    // R2: nothing fires while the configuration is illegal
    p_idle_bad_r2: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_bad) |-> !(bit_start || sample_stb));

    // R4: sampled level moves only at the sample point
    p_rxbit_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!sample_stb && !$past(cfg_bad)) |-> $stable(rx_bit));

    // R3: the segment counter never runs dry
    p_rem_live_r3: assert property (@(posedge clk) disable iff (rst)
        st_q.rem != '0);

    // R3: a bit start always leaves the sequencer in propagation
    p_start_prop_r3: assert property (@(posedge clk) disable iff (rst)
        bit_start |-> (st_q.seg == SEG_PROP));

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
    import cbt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tq_en,
    input  logic [SEG_W-1:0] prop_len,
    input  logic [SEG_W-1:0] ph1_len,
    input  logic [SEG_W-1:0] ph2_len,
    input  logic [SJW_W-1:0] sjw_len,
    input  logic             rx_in,
    input  logic             hsync_req,
    output logic             rx_bit,
    output logic             sample_stb,
    output logic             bit_start,
    output logic             cfg_err
);

    bt_cfg_t cfg;
    logic    cfg_bad;
    logic    fall;

    always_comb begin
        cfg.prop = prop_len;
        cfg.ph1  = ph1_len;
        cfg.ph2  = ph2_len;
        cfg.sjw  = sjw_len;
    end

    cbt_cfg_check u_cfg (
        .cfg     (cfg),
        .cfg_bad (cfg_bad)
    );

    cbt_edge_det u_edge (
        .clk   (clk),
        .rst   (rst),
        .tq_en (tq_en),
        .rx_in (rx_in),
        .fall  (fall)
    );

    cbt_seg_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .tq_en      (tq_en),
        .cfg        (cfg),
        .cfg_bad    (cfg_bad),
        .rx_in      (rx_in),
        .fall       (fall),
        .hsync      (hsync_req),
        .bit_start  (bit_start),
        .sample_stb (sample_stb),
        .rx_bit     (rx_bit)
    );

    assign cfg_err = cfg_bad;

endmodule

// File: tb/tb_can_bit_timer.sv
`timescale 1ns/1ps
module tb_can_bit_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tq_en = 1'b0;
    logic [3:0] prop_len = 4'd2;
    logic [3:0] ph1_len = 4'd4;
    logic [3:0] ph2_len = 4'd3;
    logic [2:0] sjw_len = 3'd2;
    logic       rx_in = 1'b1;
    logic       hsync_req = 1'b0;
    logic       rx_bit, sample_stb, bit_start, cfg_err;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    logic rx_pat [64];
    bit   ebs [64];
    bit   esm [64];
    bit   esv [64];
    int   hs_at = -1;

    always #5 clk = ~clk;

    can_bit_timer dut (
        .clk(clk), .rst(rst), .tq_en(tq_en),
        .prop_len(prop_len), .ph1_len(ph1_len), .ph2_len(ph2_len), .sjw_len(sjw_len),
        .rx_in(rx_in), .hsync_req(hsync_req),
        .rx_bit(rx_bit), .sample_stb(sample_stb), .bit_start(bit_start), .cfg_err(cfg_err)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic start(int p, int a, int b, int s);
        @(negedge clk);
        rst = 1'b1; tq_en = 1'b0; hsync_req = 1'b0; rx_in = 1'b1;
        prop_len = 4'(p); ph1_len = 4'(a); ph2_len = 4'(b); sjw_len = 3'(s);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic clear_exp();
        for (int i = 0; i < 64; i++) begin
            rx_pat[i] = 1'b1; ebs[i] = 1'b0; esm[i] = 1'b0; esv[i] = 1'b0;
        end
        hs_at = -1;
    endtask

    // one enabled quantum, then one idle clock; outputs sampled at negedges
    task automatic run_pat(int nt, string tbs, string tsm);
        for (int n = 0; n < nt; n++) begin
            @(negedge clk);
            if (n > 0) begin
                check("R12 idle bit_start", int'(bit_start), 0);
                check("R12 idle sample_stb", int'(sample_stb), 0);
            end
            tq_en = 1'b1; rx_in = rx_pat[n]; hsync_req = (n == hs_at);
            @(negedge clk);
            tq_en = 1'b0; hsync_req = 1'b0;
            check(tbs, int'(bit_start), int'(ebs[n]));
            check(tsm, int'(sample_stb), int'(esm[n]));
            if (esm[n]) check({tsm, " level"}, int'(rx_bit), int'(esv[n]));
        end
    endtask

    initial begin
        int lt, ok;
        // R11 reset state
        start(2, 4, 3, 2);
        @(negedge clk);
        check("R11 bit_start", int'(bit_start), 0);
        check("R11 sample_stb", int'(sample_stb), 0);
        check("R11 rx_bit", int'(rx_bit), 1);
        check("R1 legal cfg", int'(cfg_err), 0);

        // R1 sweep over all codes
        for (int p = 0; p < 16; p++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    for (int s = 0; s < 8; s++) begin
                        @(negedge clk);
                        prop_len = 4'(p); ph1_len = 4'(a); ph2_len = 4'(b); sjw_len = 3'(s);
                        #1;
                        lt = 1 + p + a + b;
                        ok = (p >= 1 && p <= 8 && a >= 2 && a <= 8 && b >= 2 && b <= 8 &&
                              s >= 1 && s <= 4 && a >= b && b >= s && lt >= 8 && lt <= 25) ? 1 : 0;
                        check("R1 cfg_err", int'(cfg_err), 1 - ok);
                    end

        // R2 idle while illegal, fresh start when legal
        start(0, 4, 3, 2);
        for (int n = 0; n < 8; n++) begin
            @(negedge clk); tq_en = 1'b1; rx_in = n[0];
            @(negedge clk); tq_en = 1'b0;
            check("R2 idle bit_start", int'(bit_start), 0);
            check("R2 idle sample_stb", int'(sample_stb), 0);
            check("R2 cfg_err", int'(cfg_err), 1);
        end
        @(negedge clk); prop_len = 4'd2; rx_in = 1'b1; tq_en = 1'b1;
        @(negedge clk); tq_en = 1'b0;
        check("R2 restart at sync", int'(bit_start), 1);

        // R3/R4 nominal timing over every legal configuration
        for (int p = 1; p <= 8; p++)
            for (int a = 2; a <= 8; a++)
                for (int b = 2; b <= a; b++)
                    for (int s = 1; s <= 4 && s <= b; s++) begin
                        lt = 1 + p + a + b;
                        if (lt >= 8) begin
                            start(p, a, b, s);
                            clear_exp();
                            for (int n = 0; n < 2 * lt; n++) begin
                                ebs[n] = ((n % lt) == 0);
                                esm[n] = ((n % lt) == p + a);
                                esv[n] = 1'b1;
                            end
                            run_pat(2 * lt, "R3 bit_start", "R4 sample_stb");
                        end
                    end

        // R5/R6/R7 single falling edge at every index
        for (int c = 0; c < 4; c++) begin
            int p, a, b, s;
            p = (c == 0) ? 2 : (c == 1) ? 1 : (c == 2) ? 8 : 3;
            a = (c == 0) ? 4 : (c == 1) ? 3 : (c == 2) ? 8 : 5;
            b = (c == 0) ? 3 : (c == 1) ? 3 : (c == 2) ? 8 : 2;
            s = (c == 0) ? 2 : (c == 1) ? 3 : (c == 2) ? 4 : 1;
            lt = 1 + p + a + b;
            for (int e = 0; e < lt; e++) begin
                int s1, v1, sb, k;
                string tg;
                if (e == 0) begin
                    s1 = p + a; v1 = 0; sb = lt; tg = "R7";
                end else if (e <= p + a) begin
                    k = (e < s) ? e : s;
                    s1 = p + a + k; v1 = 0; sb = lt + k; tg = "R5";
                end else begin
                    k = (lt - 1 - e < s) ? lt - 1 - e : s;
                    s1 = p + a; v1 = 1; sb = lt - k; tg = "R6";
                end
                start(p, a, b, s);
                clear_exp();
                for (int n = 0; n < 64; n++) rx_pat[n] = (n < e);
                ebs[0] = 1'b1; ebs[sb] = 1'b1; ebs[sb + lt] = 1'b1;
                esm[s1] = 1'b1; esv[s1] = v1[0];
                esm[sb + p + a] = 1'b1; esv[sb + p + a] = 1'b0;
                run_pat(sb + lt + 1, {tg, " bit_start"}, {tg, " sample_stb"});
            end
        end

        // R9 edges ignored after a dominant sample
        start(2, 4, 3, 2);
        clear_exp();
        for (int n = 0; n < 64; n++) rx_pat[n] = (n == 11);
        ebs[0] = 1; ebs[10] = 1; ebs[20] = 1;
        esm[6] = 1; esm[16] = 1;
        run_pat(21, "R9 bit_start", "R9 sample_stb");

        // R8 only the first of two edges in a bit counts
        start(2, 4, 3, 2);
        clear_exp();
        for (int n = 0; n < 64; n++) rx_pat[n] = (n == 0 || n == 2 || n == 3);
        ebs[0] = 1; ebs[11] = 1; ebs[21] = 1;
        esm[7] = 1; esm[17] = 1;
        run_pat(22, "R8 bit_start", "R8 sample_stb");

        // R10 hard sync before and after the sample point
        for (int hi = 0; hi < 2; hi++) begin
            int h;
            h = (hi == 0) ? 3 : 8;
            start(2, 4, 3, 2);
            clear_exp();
            hs_at = h;
            ebs[0] = 1; ebs[h] = 1; ebs[h + 10] = 1;
            if (6 < h) begin esm[6] = 1; esv[6] = 1; end
            esm[h + 6] = 1; esv[h + 6] = 1;
            run_pat(h + 11, "R10 bit_start", "R10 sample_stb");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule